// File: doc/BRIEF.md
# Vector Line Aligner

This block sits between a vector load/store unit and a memory that only handles whole, aligned vector lines of `VBYTES` bytes. It accepts one vector request at a time. Aligned requests drop the address bits below the line size and touch exactly one line. Unaligned requests may straddle a line boundary. For those, the block issues two line beats and builds the result: a load rotates and merges the two lines, and a store splits the vector into two lines with per-byte write enables.

Stores can also be predicated by a per-byte mask. In the true sense, only the bytes whose mask bit is set are written. In the inverted sense, only the bytes whose mask bit is clear are written. Predication applies to both aligned and unaligned stores. Bit i of the mask always refers to byte i of the store vector, wherever that byte lands in memory.

The memory side uses a valid/ready handshake with at most one request in flight. Read data returns on a separate valid strobe. Each request ends with a one-cycle response pulse.

Top module: `vec_line_aligner`

## Requirements
- R1: Request kind encoding: bit 0 set means store, bit 1 set means unaligned. For an aligned request (kind 0 = load, 1 = store), the address bits below log2(VBYTES) are ignored. Exactly one beat goes to line `addr >> log2(VBYTES)`. An unmasked aligned store enables every byte of that line.
- R2: An unaligned load (kind 2) at byte address A returns in `rsp_data` the VBYTES bytes at A, A+1, …, A+VBYTES-1. Byte i of the result is bits [8i+7:8i], taken from two consecutive lines.
- R3: An unaligned store (kind 3) at address A writes vector byte i to address A+i for every i. Every other byte of both lines it touches keeps its previous value.
- R4: An unaligned request whose address is a multiple of VBYTES makes a single line beat.
- R5: A two-beat request first issues the lower line L and then line L+1.
- R6: With `req_pred_en` set and `req_pred_inv` clear, a store writes vector byte i only when `req_pmask[i]` is 1. Bytes whose bit is 0 keep their memory contents.
- R7: With `req_pred_en` and `req_pred_inv` both set, a store writes vector byte i only when `req_pmask[i]` is 0.
- R8: Loads ignore the predicate inputs. Read beats drive `mem_be` to all zeros.
- R9: Once `mem_valid` is raised, it and the beat payload stay stable until `mem_ready`. No new beat is issued while read data is still owed.
- R10: `req_ready` is high only when the block is idle. It falls in the cycle after a request is accepted and stays low until the response has been given. `busy` is its inverse.
- R11: After reset, `req_ready` is 1 and `mem_valid`, `rsp_valid` and `busy` are 0.
- R12: Each request gets exactly one `rsp_valid` pulse, one cycle long. It comes the cycle after the last write handshake, or the cycle after the last read data. For a store, `rsp_data` is zero. The block is ready again in the cycle that follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_kind | input | 2 | bit0 store, bit1 unaligned |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*VBYTES | Store vector, byte i at bits [8i+7:8i] |
| req_pmask | input | VBYTES | Per-byte store predicate |
| req_pred_en | input | 1 | Apply predicate to a store |
| req_pred_inv | input | 1 | Invert predicate sense |
| mem_valid | output | 1 | Line beat offered |
| mem_ready | input | 1 | Memory takes the beat |
| mem_write | output | 1 | Beat is a write |
| mem_line | output | ADDR_W-log2(VBYTES) | Line index |
| mem_wdata | output | 8*VBYTES | Line write data |
| mem_be | output | VBYTES | Line byte enables |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8*VBYTES | Read line data |
| rsp_valid | output | 1 | Request complete |
| rsp_data | output | 8*VBYTES | Load result |
| busy | output | 1 | Request in progress |

## Verification
A wrong rotate offset or a stale lower-line buffer shows up in the load response of that same request as bytes shifted or drawn from the wrong line. A wrong enable window shows up as corrupted neighbour bytes, which the bench finds on its next whole-memory comparison right after the response. A wrong beat counter shows up at once as a wrong line index or a wrong beat count on the memory port, or as a missing or doubled response. Memory stalls expose payload that changes before acceptance, and the bench model flags any beat issued while a read is still owed.

// File: rtl/vla_pkg.sv
package vla_pkg;
   typedef enum logic [1:0] {
      VLA_IDLE  = 2'd0,
      VLA_ISSUE = 2'd1,
      VLA_WAITR = 2'd2,
      VLA_RESP  = 2'd3
   } vla_state_e;

   localparam int KIND_STORE_BIT = 0;
   localparam int KIND_UNAL_BIT  = 1;
endpackage

// File: rtl/vla_load_align.sv
module vla_load_align #(
   parameter int NB = 128,
   localparam int OFF_W = $clog2(NB),
   localparam int VB_W  = NB * 8
) (
   input  logic [VB_W-1:0]  lo_line,
   input  logic [VB_W-1:0]  hi_line,
   input  logic [OFF_W-1:0] off,
   output logic [VB_W-1:0]  data
);
   logic [2*VB_W-1:0] window;
   assign window = {hi_line, lo_line};

   for (genvar gi = 0; gi < NB; gi++) begin : g_byte
      logic [OFF_W:0] src;
      assign src = (OFF_W+1)'(gi) + {1'b0, off};
      assign data[gi*8 +: 8] = window[int'(src)*8 +: 8];
   end
endmodule

// File: rtl/vla_store_lanes.sv
module vla_store_lanes #(
   parameter int NB = 128,
   localparam int OFF_W = $clog2(NB),
   localparam int VB_W  = NB * 8
) (
   input  logic [VB_W-1:0]  wvec,
   input  logic [NB-1:0]    pmask,
   input  logic             pred_en,
   input  logic             pred_inv,
   input  logic [OFF_W-1:0] off,
   input  logic             upper,
   output logic [VB_W-1:0]  line_data,
   output logic [NB-1:0]    line_be
);
   for (genvar gj = 0; gj < NB; gj++) begin : g_lane
      localparam logic [OFF_W-1:0] JV = OFF_W'(gj);
      logic [OFF_W-1:0] vidx;
      logic             in_win;
      logic             keep;
      assign vidx   = JV - off;
      assign in_win = upper ? (JV < off) : (JV >= off);
      assign keep   = pred_en ? (pmask[vidx] ^ pred_inv) : 1'b1;
      assign line_be[gj] = in_win & keep;
      assign line_data[gj*8 +: 8] = wvec[int'(vidx)*8 +: 8];
   end

   // Unpredicated beats enable a contiguous run sized by the offset.
   always_comb begin
      if (!pred_en) begin
         p_window_size_r3: assert ($countones(line_be) ==
                                   (upper ? int'(off) : NB - int'(off)));
      end
   end
endmodule

// File: rtl/vla_ctrl.sv
module vla_ctrl
   import vla_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_fire,
   input  logic two_beat,
   input  logic is_store,
   input  logic mem_ready,
   input  logic mem_rvalid,
   output logic req_ready,
   output logic mem_valid,
   output logic beat,
   output logic cap_lo,
   output logic cap_rsp,
   output logic rsp_valid
);
   vla_state_e state_q, state_d;
   logic       beat_q, beat_d;
   logic       last_beat;

   assign last_beat = (beat_q == two_beat);

   always_comb begin
      state_d = state_q;
      beat_d  = beat_q;
      cap_lo  = 1'b0;
      cap_rsp = 1'b0;
      unique case (state_q)
         VLA_IDLE: if (req_fire) begin
            state_d = VLA_ISSUE;
            beat_d  = 1'b0;
         end
         VLA_ISSUE: if (mem_ready) begin
            if (!is_store) state_d = VLA_WAITR;
            else if (last_beat) begin
               state_d = VLA_RESP;
               cap_rsp = 1'b1;
            end else beat_d = 1'b1;
         end
         VLA_WAITR: if (mem_rvalid) begin
            if (last_beat) begin
               state_d = VLA_RESP;
               cap_rsp = 1'b1;
            end else begin
               cap_lo  = 1'b1;
               beat_d  = 1'b1;
               state_d = VLA_ISSUE;
            end
         end
         VLA_RESP: state_d = VLA_IDLE;
         default:  state_d = VLA_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= VLA_IDLE;
         beat_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
      end
   end

   assign req_ready = (state_q == VLA_IDLE);
   assign mem_valid = (state_q == VLA_ISSUE);
   assign rsp_valid = (state_q == VLA_RESP);
   assign beat      = beat_q;

   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> !req_ready);
   p_resp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));
   p_single_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !two_beat) |-> !beat);
endmodule

// File: rtl/vec_line_aligner.sv
module vec_line_aligner
   import vla_pkg::*;
#(
   parameter int VBYTES = 128,
   parameter int ADDR_W = 32,
   localparam int OFF_W  = $clog2(VBYTES),
   localparam int LINE_W = ADDR_W - OFF_W,
   localparam int VB_W   = VBYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [VB_W-1:0]   req_wdata,
   input  logic [VBYTES-1:0] req_pmask,
   input  logic              req_pred_en,
   input  logic              req_pred_inv,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [LINE_W-1:0] mem_line,
   output logic [VB_W-1:0]   mem_wdata,
   output logic [VBYTES-1:0] mem_be,
   input  logic              mem_rvalid,
   input  logic [VB_W-1:0]   mem_rdata,
   output logic              rsp_valid,
   output logic [VB_W-1:0]   rsp_data,
   output logic              busy
);
   if (VBYTES < 2 || (VBYTES & (VBYTES - 1)) != 0) begin : g_bad_vbytes
      $error("VBYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W + 1) begin : g_bad_addr
      $error("ADDR_W too small for VBYTES");
   end

   // Request capture
   logic              req_fire;
   logic              st_q, two_q, pen_q, inv_q;
   logic [LINE_W-1:0] line_q;
   logic [OFF_W-1:0]  off_q;
   logic [VB_W-1:0]   wvec_q;
   logic [VBYTES-1:0] pmask_q;
   logic [OFF_W-1:0]  req_off;
   logic              req_unal;

   assign req_fire = req_valid && req_ready;
   assign req_unal = req_kind[KIND_UNAL_BIT];
   assign req_off  = req_unal ? req_addr[OFF_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= 1'b0;
         two_q   <= 1'b0;
         pen_q   <= 1'b0;
         inv_q   <= 1'b0;
         line_q  <= '0;
         off_q   <= '0;
         wvec_q  <= '0;
         pmask_q <= '0;
      end else if (req_fire) begin
         st_q    <= req_kind[KIND_STORE_BIT];
         two_q   <= (req_off != '0);
         pen_q   <= req_pred_en;
         inv_q   <= req_pred_inv;
         line_q  <= req_addr[ADDR_W-1:OFF_W];
         off_q   <= req_off;
         wvec_q  <= req_wdata;
         pmask_q <= req_pmask;
      end
   end

   // Sequencer
   logic beat, cap_lo, cap_rsp;

   vla_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_fire),
      .two_beat  (two_q),
      .is_store  (st_q),
      .mem_ready (mem_ready),
      .mem_rvalid(mem_rvalid),
      .req_ready (req_ready),
      .mem_valid (mem_valid),
      .beat      (beat),
      .cap_lo    (cap_lo),
      .cap_rsp   (cap_rsp),
      .rsp_valid (rsp_valid)
   );

   assign busy = !req_ready;

   // Store path
   logic [VB_W-1:0]   lane_data;
   logic [VBYTES-1:0] lane_be;

   vla_store_lanes #(.NB(VBYTES)) u_lanes (
      .wvec     (wvec_q),
      .pmask    (pmask_q),
      .pred_en  (pen_q),
      .pred_inv (inv_q),
      .off      (off_q),
      .upper    (beat),
      .line_data(lane_data),
      .line_be  (lane_be)
   );

   assign mem_write = st_q;
   assign mem_line  = line_q + LINE_W'(beat);
   assign mem_wdata = st_q ? lane_data : '0;
   assign mem_be    = st_q ? lane_be : '0;

   // Load path
   logic [VB_W-1:0] lo_q, rsp_q, merged;

   vla_load_align #(.NB(VBYTES)) u_align (
      .lo_line(two_q ? lo_q : mem_rdata),
      .hi_line(mem_rdata),
      .off    (off_q),
      .data   (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         rsp_q <= '0;
      end else begin
         if (cap_lo) lo_q <= mem_rdata;
         if (cap_rsp) rsp_q <= st_q ? '0 : merged;
      end
   end

   assign rsp_data = rsp_q;

   // Protocol watch state for the assertions below
   logic              rd_owed_q;
   logic [LINE_W-1:0] first_line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_owed_q    <= 1'b0;
         first_line_q <= '0;
      end else begin
         if (mem_valid && mem_ready && !mem_write) rd_owed_q <= 1'b1;
         else if (mem_rvalid) rd_owed_q <= 1'b0;
         if (mem_valid && mem_ready && !beat) first_line_q <= mem_line;
      end
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_line) &&
                                     $stable(mem_be) && $stable(mem_write)));
   p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_owed_q |-> !mem_valid);
   p_upper_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && beat) |-> (mem_line == first_line_q + LINE_W'(1)));
   p_read_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_write) |-> (mem_be == '0));
endmodule

// File: tb/vec_line_aligner_bench.sv
module vec_line_aligner_bench;
   localparam int NB     = 128;
   localparam int AW     = 32;
   localparam int VB_W   = NB * 8;
   localparam int LW     = AW - 7;
   localparam int MBYTES = 16 * NB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            req_valid = 1'b0, req_ready;
   logic [1:0]      req_kind = '0;
   logic [AW-1:0]   req_addr = '0;
   logic [VB_W-1:0] req_wdata = '0;
   logic [NB-1:0]   req_pmask = '0;
   logic            req_pred_en = 1'b0, req_pred_inv = 1'b0;
   logic            mem_valid, mem_write;
   logic            mem_ready = 1'b0;
   logic [LW-1:0]   mem_line;
   logic [VB_W-1:0] mem_wdata, mem_rdata = '0, rsp_data;
   logic [NB-1:0]   mem_be;
   logic            mem_rvalid = 1'b0, rsp_valid, busy;

   vec_line_aligner u_vec_line_aligner (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_pmask(req_pmask), .req_pred_en(req_pred_en), .req_pred_inv(req_pred_inv),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_line(mem_line), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .busy(busy)
   );

   int n_checks = 0, n_fail = 0;
   logic [7:0] mem [MBYTES];
   logic [7:0] shadow [MBYTES];

   // Memory model
   logic       stall_mode = 1'b0;
   logic [7:0] lfsr = 8'h5a;
   logic       rd_pend = 1'b0;
   logic [3:0] rd_line = '0;
   int         beats = 0;
   int         viol = 0;
   logic [3:0] beat_line [2];

   always @(posedge clk) begin
      lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready  <= stall_mode ? lfsr[0] : 1'b1;
      mem_rvalid <= 1'b0;
      if (rd_pend) begin
         for (int j = 0; j < NB; j++) mem_rdata[j*8 +: 8] <= mem[{rd_line, 7'(j)}];
         mem_rvalid <= 1'b1;
         rd_pend    <= 1'b0;
      end
      if (mem_valid && (rd_pend || mem_rvalid)) viol <= viol + 1;
      if (mem_valid && mem_ready) begin
         if (beats < 2) beat_line[beats] <= mem_line[3:0];
         beats <= beats + 1;
         if (mem_write) begin
            for (int j = 0; j < NB; j++)
               if (mem_be[j]) mem[{mem_line[3:0], 7'(j)}] <= mem_wdata[j*8 +: 8];
         end else begin
            rd_pend <= 1'b1;
            rd_line <= mem_line[3:0];
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [VB_W-1:0] mk_vec(input logic [7:0] seed);
      logic [VB_W-1:0] v;
      for (int i = 0; i < NB; i++) v[i*8 +: 8] = seed + 8'(i * 5);
      return v;
   endfunction

   // Issue one request and check it against the requirement model.
   task automatic run(input string req, input logic [1:0] kind, input int addr,
                      input logic [VB_W-1:0] wd, input logic [NB-1:0] pm,
                      input bit pen, input bit inv);
      int start, nbeats, guard, mism;
      logic [VB_W-1:0] exp_data;
      logic [VB_W-1:0] got;
      bit st;
      st     = kind[0];
      start  = kind[1] ? addr : (addr & ~(NB - 1));
      nbeats = (kind[1] && (addr % NB) != 0) ? 2 : 1;
      for (int i = 0; i < NB; i++) begin
         exp_data[i*8 +: 8] = shadow[start + i];
         if (st && (!pen || (pm[i] ^ inv))) shadow[start + i] = wd[i*8 +: 8];
      end
      if (st) exp_data = '0;
      @(negedge clk);
      beats = 0;
      req_kind = kind; req_addr = AW'(addr); req_wdata = wd;
      req_pmask = pm; req_pred_en = pen; req_pred_inv = inv; req_valid = 1'b1;
      guard = 0;
      while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready && busy, "R10", "ready after accept", req_ready, 0);
      guard = 0;
      while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
      check(guard < 2000, req, "watchdog response", guard, 0);
      got = rsp_data;
      check(beats == nbeats, nbeats == 2 ? "R5" : "R4", "beat count", beats, nbeats);
      check(beat_line[0] == 4'(start / NB), "R1", "first line", beat_line[0], start / NB);
      if (nbeats == 2)
         check(beat_line[1] == 4'(start / NB + 1), "R5", "second line",
               beat_line[1], start / NB + 1);
      mism = 0;
      for (int i = 0; i < NB; i++) if (got[i*8 +: 8] !== exp_data[i*8 +: 8]) mism++;
      check(mism == 0, st ? "R12" : req, "response bytes wrong", mism, 0);
      @(negedge clk);
      check(!rsp_valid && req_ready, "R12", "pulse end", rsp_valid, 0);
      mism = 0;
      for (int a = 0; a < MBYTES; a++) if (mem[a] !== shadow[a]) mism++;
      check(mism == 0, req, "memory bytes wrong", mism, 0);
   endtask

   task automatic t_reset();
      check(req_ready && !mem_valid && !rsp_valid && !busy, "R11", "reset state",
            {req_ready, mem_valid, rsp_valid, busy}, 4'b1000);
   endtask

   task automatic t_aligned();
      run("R1", 2'd0, 13, '0, '0, 1'b0, 1'b0);
      run("R1", 2'd1, NB + 13, mk_vec(8'h11), '0, 1'b0, 1'b0);
   endtask

   task automatic t_unaligned_load();
      run("R2", 2'd2, 2 * NB + 12, '0, '0, 1'b0, 1'b0);
      run("R2", 2'd2, 2 * NB + NB - 1, '0, '0, 1'b0, 1'b0);
      run("R4", 2'd2, 3 * NB, '0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_unaligned_store();
      run("R3", 2'd3, 4 * NB + 12, mk_vec(8'h40), '0, 1'b0, 1'b0);
      run("R3", 2'd3, 8 * NB + NB - 1, mk_vec(8'h90), '0, 1'b0, 1'b0);
      run("R4", 2'd3, 10 * NB, mk_vec(8'h23), '0, 1'b0, 1'b0);
   endtask

   task automatic t_masked();
      logic [NB-1:0] pm;
      for (int i = 0; i < NB; i++) pm[i] = (i % 3 == 0);
      run("R6", 2'd1, 6 * NB + 5, mk_vec(8'hA0), pm, 1'b1, 1'b0);
      run("R7", 2'd1, 7 * NB, mk_vec(8'hB3), pm, 1'b1, 1'b1);
      run("R6", 2'd3, 11 * NB + 40, mk_vec(8'hC7), pm, 1'b1, 1'b0);
      run("R7", 2'd3, 12 * NB + 77, mk_vec(8'hD1), pm, 1'b1, 1'b1);
   endtask

   task automatic t_load_pred();
      run("R8", 2'd2, 6 * NB + 33, '0, '0, 1'b1, 1'b0);
      run("R8", 2'd0, 7 * NB, '0, {NB{1'b1}}, 1'b1, 1'b1);
   endtask

   task automatic t_stalls();
      stall_mode = 1'b1;
      run("R2", 2'd2, 5 * NB + 70, '0, '0, 1'b0, 1'b0);
      run("R3", 2'd3, 13 * NB + 3, mk_vec(8'h5E), '0, 1'b0, 1'b0);
      run("R1", 2'd1, 14 * NB + 100, mk_vec(8'h77), '0, 1'b0, 1'b0);
      stall_mode = 1'b0;
      check(viol == 0, "R9", "beat while read owed", viol, 0);
   endtask

   initial begin
      for (int a = 0; a < MBYTES; a++) begin
         mem[a]    = 8'(a * 7 + (a / NB) * 13 + 3);
         shadow[a] = 8'(a * 7 + (a / NB) * 13 + 3);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned();
      t_unaligned_load();
      t_unaligned_store();
      t_masked();
      t_load_pred();
      t_stalls();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule